// File: doc/BRIEF.md
# Dual-Frame Asynchronous Serial Transmitter

This block drives one asynchronous serial line. A character is handed over as a 16-bit word on a valid/ready write port, together with mode pins. The block sends it as one frame: a low start bit, the data bits, an optional parity bit, then one or two high stop bits. Characters may be 7, 8 or 9 data bits long. In two-frame mode one write carries two bytes. They leave as two frames back to back, and completion is signalled only once, after the second frame.

Bit timing comes from a single-cycle `baud_tick` input. Each tick ends the bit currently on the line and starts the next one. The write port applies no back-pressure to the line: `wr_ready` is high exactly while the transmitter is idle. A word offered while `wr_ready` is low is not taken and leaves no trace, so the source must hold `wr_valid` and its data until it sees `wr_ready`. The mode pins are sampled only in the accepting cycle. `tx_busy` reports a transmission in progress, and `tx_done` pulses once at its end.

Top module: `dfu_uart_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_busy` and `tx_done` are 0 and `wr_ready` is 1; whenever `tx_busy` is 0, `txd` is 1.
- R2: A word is accepted in a cycle with `wr_valid` and `wr_ready` both high; `wr_ready` is low while busy, and a word offered then has no effect on the line or the outcome.
- R3: After acceptance `txd` stays high until the next `baud_tick`. From then on each `baud_tick` ends the bit being sent, and `txd` changes only in the cycle after a tick.
- R4: A frame is a start bit of 0, the data bits least significant first, an optional parity bit, then one stop bit of 1, or two when `cfg_stop2` is 1.
- R5: `cfg_len` 0 sends data bits [6:0], 1 sends [7:0], and 2 or 3 sends [8:0]. Bits above the selected length are not sent.
- R6: `cfg_parity` 0 adds no parity bit. 1 adds even parity, 2 adds odd parity and 3 adds a constant 0. Parity covers only the data bits that are sent.
- R7: With `cfg_dual` 1, bits [7:0] are sent as a first frame and bits [15:8] as a second. A length setting of 2 or 3 is sent as 8 bits. The second start bit follows the first frame's last stop bit with no idle tick between them.
- R8: `tx_done` is a one-cycle pulse, raised in the cycle `tx_busy` falls, once per accepted word. In two-frame mode it comes only after the second frame.
- R9: `tx_busy` rises in the cycle after acceptance and stays high until the `tx_done` cycle.
- R10: The mode pins and data are captured at acceptance; changing them during a transmission has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Transmitter idle, word will be taken |
| wr_data | input | 16 | Character, or two bytes in two-frame mode |
| cfg_len | input | 2 | Character length: 0=7, 1=8, 2/3=9 bits |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 zero |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_dual | input | 1 | Two-frame mode when 1 |
| txd | output | 1 | Serial line, idles high |
| tx_busy | output | 1 | Transmission in progress |
| tx_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong bit counter or shift register shows on `txd` at the first tick after the bad bit. Because the bench compares the line at every tick, the error is caught within one bit time. A second-frame flag that is set wrongly or lost shows in one of two ways. Either `tx_done` arrives after the wrong number of ticks, or the line goes idle where the second start bit belongs, within one frame. A latch of data or mode that should have held but did not shows up as a wrong bit or wrong frame length in the same transmission.

// File: rtl/dfu_tx_pkg.sv
package dfu_tx_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int CHAR_MAX = BYTE_W + 1;
  localparam int FRAME_W  = CHAR_MAX + 4;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD, PAR_ZERO} parity_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SEND} seq_state_e;

  typedef struct packed {
    logic [1:0] len;
    parity_e    par;
    logic       stop2;
    logic       dual;
  } tx_cfg_t;
endpackage

// File: rtl/dfu_frame_builder.sv
module dfu_frame_builder
  import dfu_tx_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int WW = WORD_W,
  parameter int CM = CHAR_MAX,
  parameter int FW = FRAME_W,
  parameter int CW = CNT_W
) (
  input  logic [WW-1:0] word_i,
  input  logic          use_hi_i,
  input  tx_cfg_t       cfg_i,
  output logic [FW-1:0] frame_o,
  output logic [CW-1:0] len_o
);
  logic [CM-1:0] chr;
  logic [CM-1:0] sent;
  logic          pbit;
  int            nd;
  int            pos;

  always_comb begin
    if (cfg_i.len == 2'd0)                      nd = BW - 1;
    else if (cfg_i.len == 2'd1 || cfg_i.dual)   nd = BW;
    else                                        nd = CM;

    if (cfg_i.dual)
      chr = use_hi_i ? {{(CM-BW){1'b0}}, word_i[WW-1:BW]}
                     : {{(CM-BW){1'b0}}, word_i[BW-1:0]};
    else
      chr = word_i[CM-1:0];

    for (int i = 0; i < CM; i++) sent[i] = (i < nd) ? chr[i] : 1'b0;

    case (cfg_i.par)
      PAR_EVEN: pbit = ^sent;
      PAR_ODD:  pbit = ~^sent;
      default:  pbit = 1'b0;
    endcase

    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < CM; i++)
      if (i < nd) frame_o[i+1] = chr[i];
    pos = nd + 1;
    if (cfg_i.par != PAR_NONE) begin
      frame_o[pos] = pbit;
      pos = pos + 1;
    end
    len_o = CW'(pos + (cfg_i.stop2 ? 2 : 1));
  end
endmodule

// File: rtl/dfu_bit_shifter.sv
module dfu_bit_shifter
  import dfu_tx_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [FW-1:0] frame_i,
  input  logic [CW-1:0] len_i,
  input  logic          adv_i,
  input  logic          stop_i,
  output logic          txd_o,
  output logic          last_o
);
  logic [FW-1:0] sreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg  <= '1;
      left  <= '0;
      txd_o <= 1'b1;
    end else if (load_i) begin
      txd_o <= frame_i[0];
      sreg  <= {1'b1, frame_i[FW-1:1]};
      left  <= len_i - CW'(1);
    end else if (adv_i) begin
      txd_o <= sreg[0];
      sreg  <= {1'b1, sreg[FW-1:1]};
      left  <= left - CW'(1);
    end else if (stop_i) begin
      txd_o <= 1'b1;
    end
  end

  assign last_o = (left == '0);
endmodule

// File: rtl/dfu_sequencer.sv
module dfu_sequencer
  import dfu_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic accept_i,
  input  logic dual_i,
  input  logic last_i,
  output logic load_o,
  output logic adv_o,
  output logic stop_o,
  output logic use_hi_o,
  output logic busy_o,
  output logic done_o
);
  seq_state_e state;
  logic       second_left;

  always_comb begin
    load_o = tick_i && ((state == ST_LEAD) ||
                        (state == ST_SEND && last_i && second_left));
    adv_o  = tick_i && (state == ST_SEND) && !last_i;
    stop_o = tick_i && (state == ST_SEND) && last_i && !second_left;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      second_left <= 1'b0;
      use_hi_o    <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= stop_o;
      case (state)
        ST_IDLE: if (accept_i) begin
          state       <= ST_LEAD;
          use_hi_o    <= 1'b0;
          second_left <= 1'b0;
        end
        ST_LEAD: if (tick_i) begin
          state       <= ST_SEND;
          second_left <= dual_i;
          use_hi_o    <= dual_i;
        end
        ST_SEND: begin
          if (load_o) second_left <= 1'b0;
          if (stop_o) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/dfu_uart_tx.sv
module dfu_uart_tx
  import dfu_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baud_tick,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [15:0] wr_data,
  input  logic [1:0]  cfg_len,
  input  logic [1:0]  cfg_parity,
  input  logic        cfg_stop2,
  input  logic        cfg_dual,
  output logic        txd,
  output logic        tx_busy,
  output logic        tx_done
);
  logic [WORD_W-1:0]  word_q;
  tx_cfg_t            cfg_q;
  logic               accept;
  logic               load, adv, stop, last, use_hi;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   flen;

  assign wr_ready = !tx_busy;
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      cfg_q  <= '0;
    end else if (accept) begin
      word_q      <= wr_data;
      cfg_q.len   <= cfg_len;
      cfg_q.par   <= parity_e'(cfg_parity);
      cfg_q.stop2 <= cfg_stop2;
      cfg_q.dual  <= cfg_dual;
    end
  end

  dfu_frame_builder u_build (
    .word_i(word_q), .use_hi_i(use_hi), .cfg_i(cfg_q),
    .frame_o(frame), .len_o(flen)
  );

  dfu_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(baud_tick), .accept_i(accept),
    .dual_i(cfg_q.dual), .last_i(last), .load_o(load), .adv_o(adv),
    .stop_o(stop), .use_hi_o(use_hi), .busy_o(tx_busy), .done_o(tx_done)
  );

  dfu_bit_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .frame_i(frame), .len_i(flen),
    .adv_i(adv), .stop_i(stop), .txd_o(txd), .last_o(last)
  );
endmodule

// File: rtl/dfu_tx_checks.sv
module dfu_tx_checks (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic wr_valid,
  input logic wr_ready,
  input logic txd,
  input logic tx_busy,
  input logic tx_done
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> tx_busy);
  assert_lead_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> txd);
  assert_tick_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_busy && $past(tx_busy)));
endmodule

bind dfu_uart_tx dfu_tx_checks u_checks (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .txd(txd), .tx_busy(tx_busy), .tx_done(tx_done)
);

// File: tb/tb_dfu_uart_tx.sv
module tb_dfu_uart_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic [1:0]  cfg_len = '0;
  logic [1:0]  cfg_parity = '0;
  logic        cfg_stop2 = 1'b0;
  logic        cfg_dual = 1'b0;
  logic        txd, tx_busy, tx_done;

  typedef struct { logic b; string tag; } exp_bit_t;
  exp_bit_t exp_q[$];
  int       len_q[$];
  int       checks = 0, errors = 0, writes = 0, dones = 0, bitcnt = 0;
  int       tick_div = 0;

  always #4 clk = ~clk;

  dfu_uart_tx dut (.*);

  always @(posedge clk) begin
    tick_div  <= (tick_div == 5) ? 0 : tick_div + 1;
    baud_tick <= (tick_div == 5);
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int push_frame(input logic [8:0] ch, input int nd,
                                    input logic [1:0] pr, input logic s2,
                                    input string st_tag);
    int ones = 0;
    int n = 0;
    exp_q.push_back('{1'b0, st_tag}); n++;
    for (int i = 0; i < nd; i++) begin
      exp_q.push_back('{ch[i], "R5"}); n++;
      if (ch[i]) ones++;
    end
    if (pr != 2'd0) begin
      logic p;
      p = (pr == 2'd1) ? logic'(ones % 2) : (pr == 2'd2) ? logic'(!(ones % 2)) : 1'b0;
      exp_q.push_back('{p, "R6"}); n++;
    end
    exp_q.push_back('{1'b1, "R4"}); n++;
    if (s2) begin exp_q.push_back('{1'b1, "R4"}); n++; end
    return n;
  endfunction

  task automatic send(input logic [15:0] d, input logic [1:0] ln,
                      input logic [1:0] pr, input logic s2, input logic dl);
    int nd, n;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    nd = (ln == 2'd0) ? 7 : ((ln == 2'd1 || dl) ? 8 : 9);
    exp_q.push_back('{1'b1, "R3"});
    n = 1;
    if (dl) begin
      n += push_frame({1'b0, d[7:0]}, nd, pr, s2, "R4");
      n += push_frame({1'b0, d[15:8]}, nd, pr, s2, "R7");
    end else begin
      n += push_frame(d[8:0], nd, pr, s2, "R4");
    end
    len_q.push_back(n);
    wr_valid = 1'b1; wr_data = d; cfg_len = ln; cfg_parity = pr;
    cfg_stop2 = s2; cfg_dual = dl;
    @(negedge clk);
    wr_valid = 1'b0;
    writes++;
    chk(tx_busy && !wr_ready, "R9 busy after accept", {tx_busy, wr_ready}, 2'b10);
  endtask

  task automatic wait_idle();
    while (tx_busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(dones == writes, "R8 one done per word", dones, writes);
  endtask

  // monitor: one expected bit per tick while busy; frame length at done
  always @(negedge clk) begin
    if (rst_n && baud_tick && tx_busy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 extra bit time", txd, 1);
      end else begin
        exp_bit_t e;
        e = exp_q.pop_front();
        chk(txd === e.b, {e.tag, " line bit"}, txd, e.b);
        bitcnt++;
      end
    end
    if (rst_n && tx_done) begin
      dones++;
      chk(!tx_busy, "R8 done with busy low", tx_busy, 0);
      if (len_q.size() == 0) chk(1'b0, "R8 unexpected done", dones, writes);
      else begin
        int n;
        n = len_q.pop_front();
        chk(bitcnt == n, "R8 done after last frame", bitcnt, n);
      end
      bitcnt = 0;
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd && !tx_busy && !tx_done && wr_ready, "R1 reset state",
        {txd, tx_busy, tx_done, wr_ready}, 4'b1001);

    send(16'h00A5, 2'd1, 2'd0, 1'b0, 1'b0);  wait_idle();   // R4 8N1
    send(16'h00DB, 2'd0, 2'd1, 1'b1, 1'b0);  wait_idle();   // R5 7 bits, R6 even
    send(16'h013C, 2'd2, 2'd2, 1'b0, 1'b0);  wait_idle();   // R5 9 bits, R6 odd
    send(16'h01F0, 2'd3, 2'd3, 1'b1, 1'b0);  wait_idle();   // R6 zero parity
    send(16'h3CC3, 2'd1, 2'd1, 1'b0, 1'b1);  wait_idle();   // R7 two frames
    send(16'h817E, 2'd2, 2'd2, 1'b1, 1'b1);  wait_idle();   // R7 9 sent as 8
    send(16'hF00F, 2'd0, 2'd0, 1'b0, 1'b1);  wait_idle();   // R7 7-bit pair

    // R2 and R10: offer words while busy, change mode pins mid-frame
    send(16'h0055, 2'd1, 2'd1, 1'b0, 1'b0);
    cfg_len = 2'd2; cfg_parity = 2'd2; cfg_stop2 = 1'b1; cfg_dual = 1'b1;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      wr_valid = 1'b1; wr_data = 16'hFFFF;
      @(negedge clk);
      chk(!wr_ready, "R2 not ready while busy", wr_ready, 0);
    end
    wr_valid = 1'b0;
    wait_idle();

    // back to back words
    send(16'h0181, 2'd2, 2'd1, 1'b1, 1'b0);
    send(16'h1234, 2'd1, 2'd0, 1'b0, 1'b1);
    wait_idle();
    chk(txd && wr_ready, "R1 idle line high", {txd, wr_ready}, 2'b11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule